// File: doc/BRIEF.md
# DRAM Command Injection Register Bank

This block sits in front of a DDR3 DFI command port and decides who drives it. During bring-up, software owns the port. It writes a small set of word-addressed Wishbone registers to set the clock-enable, on-die-termination and DRAM reset pins. It stages one DRAM command (chip select, row strobe, column strobe, write enable, plus a row/column address and a bank) and fires that command with a strobe write. The command then appears on the DFI pins for a single cycle. In every other cycle the pins show a no-operation with chip select high.

When initialisation is finished, software sets the select bit. From then on the block passes the hardware controller's DFI command signals through to the port unchanged, and the strobe can no longer disturb the pins. Register offsets are relative to a byte base of 0x9000. The bus carries word addresses, so word address = (0x9000 + byte offset) >> 2.

Top module: `dfi_cmd_inject`

## Requirements
- R1: While reset is asserted and after it is released, all registers read zero and software owns the port. The DFI outputs are then cke=0, odt=0, reset_n=0, and cs_n, ras_n, cas_n and we_n all 1.
- R2: The registers decode at byte offsets from base 0x9000, with word address = byte address >> 2. The offsets are 0x00 control, 0x04 command, 0x08 strobe, 0x0C address and 0x10 bank. An access to any other word is acknowledged, reads zero, and changes no register.
- R3: Each access is acknowledged one cycle after cyc and stb are sampled high. The acknowledge lasts exactly one cycle, and it is low in the cycle the request is first presented.
- R4: A read returns the current register contents, zero-extended. Control and command keep bits 3:0, address keeps 16 bits and bank keeps 3 bits. The strobe offset always reads zero.
- R5: In software mode, control bit 1 drives dfi_cke, bit 2 drives dfi_odt and bit 3 drives dfi_reset_n. Each takes effect in the cycle in which the write is acknowledged.
- R6: In software mode, a write of 1 in bit 0 to the strobe offset makes the stored command appear on the pins for exactly one cycle, which is the acknowledge cycle. A strobe write with bit 0 clear issues nothing.
- R7: Command register bits are active-high: bit 0 chip select, bit 1 write enable, bit 2 column strobe, bit 3 row strobe. On the pins they appear active-low. Value 0x0F drives all four low, and value 0x03 drives only cs_n and we_n low.
- R8: Outside the one-cycle command, in software mode, cs_n, ras_n, cas_n and we_n are all 1.
- R9: In software mode, dfi_address and dfi_bank follow the address and bank registers.
- R10: With control bit 0 set, every DFI output equals the matching hardware-port input, and a strobe write leaves the pins unchanged. After the bit is cleared, no deferred command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DFI / bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | ADDR_W | Word address |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| hw_cke_i | input | 1 | Controller clock enable |
| hw_odt_i | input | 1 | Controller termination enable |
| hw_reset_n_i | input | 1 | Controller DRAM reset, active-low |
| hw_cs_n_i | input | 1 | Controller chip select, active-low |
| hw_ras_n_i | input | 1 | Controller row strobe, active-low |
| hw_cas_n_i | input | 1 | Controller column strobe, active-low |
| hw_we_n_i | input | 1 | Controller write enable, active-low |
| hw_address_i | input | ADR_W | Controller address |
| hw_bank_i | input | BANK_W | Controller bank |
| dfi_cke_o | output | 1 | DFI clock enable |
| dfi_odt_o | output | 1 | DFI termination enable |
| dfi_reset_n_o | output | 1 | DFI DRAM reset, active-low |
| dfi_cs_n_o | output | 1 | DFI chip select, active-low |
| dfi_ras_n_o | output | 1 | DFI row strobe, active-low |
| dfi_cas_n_o | output | 1 | DFI column strobe, active-low |
| dfi_we_n_o | output | 1 | DFI write enable, active-low |
| dfi_address_o | output | ADR_W | DFI address |
| dfi_bank_o | output | BANK_W | DFI bank |

## Verification
The hardest case to reach is a strobe written while the hardware controller owns the port. If the design holds such a strobe back, the stale command would only show up after ownership returns to software. To reach this case, the stimulus sets the select bit, stages a full mode-register command, and fires the strobe. It then checks the pins against deliberately non-idle hardware inputs in the acknowledge cycle. Finally it hands the port back and confirms that the pins stay idle. The single-cycle width of the command is checked by sampling the pins both in the acknowledge cycle and in the cycle after it.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;

  // Word index of each register relative to the block base
  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_CMD   = 3'd1,
    IDX_FIRE  = 3'd2,
    IDX_ADDR  = 3'd3,
    IDX_BANK  = 3'd4
  } reg_idx_e;

  localparam int NUM_REGS = 5;

  // Control register bits
  localparam int CTL_HWSEL = 0;
  localparam int CTL_CKE   = 1;
  localparam int CTL_ODT   = 2;
  localparam int CTL_RSTN  = 3;

  // Command register bits (active-high)
  localparam int CMD_CS  = 0;
  localparam int CMD_WE  = 1;
  localparam int CMD_CAS = 2;
  localparam int CMD_RAS = 3;

  typedef struct packed {
    logic cke;
    logic odt;
    logic reset_n;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dfi_ctl_t;

endpackage

// File: rtl/dfi_inj_rst_sync.sv
module dfi_inj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dfi_inj_regs.sv
module dfi_inj_regs
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int ADR_W     = 16,
  parameter int BANK_W    = 3,
  parameter int BASE_BYTE = 32'h9000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic [3:0]        ctrl_o,
  output logic [3:0]        cmd_o,
  output logic [ADR_W-1:0]  addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              fire_o
);
  localparam int BASE_WORD = BASE_BYTE >> 2;

  logic [ADDR_W-1:0] idx_w;
  logic              hit, accept, wr;
  logic [2:0]        idx3;

  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [3:0]        ctrl_q, ctrl_d, cmd_q, cmd_d;
  logic [ADR_W-1:0]  addr_q, addr_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              ctrl_en, cmd_en, addr_en, bank_en;
  logic              unused_dat;

  assign unused_dat = ^wb_dat_i;

  assign idx_w  = wb_adr_i - ADDR_W'(BASE_WORD);
  assign hit    = idx_w < ADDR_W'(NUM_REGS);
  assign idx3   = idx_w[2:0];
  assign accept = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr     = accept & wb_we_i & hit;

  // Clock enables
  assign ctrl_en = wr & (idx3 == 3'(IDX_CTRL));
  assign cmd_en  = wr & (idx3 == 3'(IDX_CMD));
  assign addr_en = wr & (idx3 == 3'(IDX_ADDR));
  assign bank_en = wr & (idx3 == 3'(IDX_BANK));
  assign fire_o  = wr & (idx3 == 3'(IDX_FIRE)) & wb_dat_i[0];

  // Next-state
  always_comb begin
    ack_d  = accept;
    ctrl_d = wb_dat_i[3:0];
    cmd_d  = wb_dat_i[3:0];
    addr_d = wb_dat_i[ADR_W-1:0];
    bank_d = wb_dat_i[BANK_W-1:0];
    rd_d   = '0;
    if (hit) begin
      case (idx3)
        3'(IDX_CTRL): rd_d = DATA_W'(ctrl_q);
        3'(IDX_CMD):  rd_d = DATA_W'(cmd_q);
        3'(IDX_ADDR): rd_d = DATA_W'(addr_q);
        3'(IDX_BANK): rd_d = DATA_W'(bank_q);
        default:      rd_d = '0;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rd_q   <= '0;
      ctrl_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      bank_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (accept)  rd_q   <= rd_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (addr_en) addr_q <= addr_d;
      if (bank_en) bank_q <= bank_d;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = rd_q;
  assign ctrl_o   = ctrl_q;
  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign bank_o   = bank_q;

  a_r3_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);
  a_r3_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));
endmodule

// File: rtl/dfi_inj_cmd.sv
module dfi_inj_cmd
  import dfi_inj_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic       hwsel_i,
  input  logic [3:0] cmd_i,
  output logic       pulse_o,
  output logic [3:0] pins_n_o
);
  logic pulse_q, pulse_d;

  assign pulse_d = fire_i & ~hwsel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_d;
  end

  // Active-high command bits become active-low pins only during the pulse
  for (genvar g = 0; g < 4; g++) begin : g_pin
    assign pins_n_o[g] = ~(pulse_q & cmd_i[g]);
  end

  assign pulse_o = pulse_q;

  a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dfi_inj_mux.sv
module dfi_inj_mux
  import dfi_inj_pkg::*;
#(
  parameter int ADR_W  = 16,
  parameter int BANK_W = 3
) (
  input  logic              hwsel_i,
  input  dfi_ctl_t          sw_ctl_i,
  input  logic [ADR_W-1:0]  sw_addr_i,
  input  logic [BANK_W-1:0] sw_bank_i,
  input  dfi_ctl_t          hw_ctl_i,
  input  logic [ADR_W-1:0]  hw_addr_i,
  input  logic [BANK_W-1:0] hw_bank_i,
  output dfi_ctl_t          out_ctl_o,
  output logic [ADR_W-1:0]  out_addr_o,
  output logic [BANK_W-1:0] out_bank_o
);
  always_comb begin
    if (hwsel_i) begin
      out_ctl_o  = hw_ctl_i;
      out_addr_o = hw_addr_i;
      out_bank_o = hw_bank_i;
    end else begin
      out_ctl_o  = sw_ctl_i;
      out_addr_o = sw_addr_i;
      out_bank_o = sw_bank_i;
    end
  end
endmodule

// File: rtl/dfi_cmd_inject.sv
module dfi_cmd_inject
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int ADR_W     = 16,
  parameter int BANK_W    = 3,
  parameter int BASE_BYTE = 32'h9000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  input  logic              hw_cke_i,
  input  logic              hw_odt_i,
  input  logic              hw_reset_n_i,
  input  logic              hw_cs_n_i,
  input  logic              hw_ras_n_i,
  input  logic              hw_cas_n_i,
  input  logic              hw_we_n_i,
  input  logic [ADR_W-1:0]  hw_address_i,
  input  logic [BANK_W-1:0] hw_bank_i,
  output logic              dfi_cke_o,
  output logic              dfi_odt_o,
  output logic              dfi_reset_n_o,
  output logic              dfi_cs_n_o,
  output logic              dfi_ras_n_o,
  output logic              dfi_cas_n_o,
  output logic              dfi_we_n_o,
  output logic [ADR_W-1:0]  dfi_address_o,
  output logic [BANK_W-1:0] dfi_bank_o
);
  logic              rst_n;
  logic [3:0]        ctrl, cmd, pins_n;
  logic [ADR_W-1:0]  addr;
  logic [BANK_W-1:0] bank;
  logic              fire, pulse;
  dfi_ctl_t          sw_ctl, hw_ctl, out_ctl;

  dfi_inj_rst_sync #(.STAGES(2)) i_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  dfi_inj_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_W(ADR_W),
    .BANK_W(BANK_W), .BASE_BYTE(BASE_BYTE)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .ctrl_o(ctrl), .cmd_o(cmd), .addr_o(addr), .bank_o(bank), .fire_o(fire)
  );

  dfi_inj_cmd i_cmd (
    .clk_i(clk_i), .rst_ni(rst_n), .fire_i(fire),
    .hwsel_i(ctrl[CTL_HWSEL]), .cmd_i(cmd),
    .pulse_o(pulse), .pins_n_o(pins_n)
  );

  always_comb begin
    sw_ctl.cke     = ctrl[CTL_CKE];
    sw_ctl.odt     = ctrl[CTL_ODT];
    sw_ctl.reset_n = ctrl[CTL_RSTN];
    sw_ctl.cs_n    = pins_n[CMD_CS];
    sw_ctl.ras_n   = pins_n[CMD_RAS];
    sw_ctl.cas_n   = pins_n[CMD_CAS];
    sw_ctl.we_n    = pins_n[CMD_WE];
    hw_ctl.cke     = hw_cke_i;
    hw_ctl.odt     = hw_odt_i;
    hw_ctl.reset_n = hw_reset_n_i;
    hw_ctl.cs_n    = hw_cs_n_i;
    hw_ctl.ras_n   = hw_ras_n_i;
    hw_ctl.cas_n   = hw_cas_n_i;
    hw_ctl.we_n    = hw_we_n_i;
  end

  dfi_inj_mux #(.ADR_W(ADR_W), .BANK_W(BANK_W)) i_mux (
    .hwsel_i(ctrl[CTL_HWSEL]),
    .sw_ctl_i(sw_ctl), .sw_addr_i(addr), .sw_bank_i(bank),
    .hw_ctl_i(hw_ctl), .hw_addr_i(hw_address_i), .hw_bank_i(hw_bank_i),
    .out_ctl_o(out_ctl), .out_addr_o(dfi_address_o), .out_bank_o(dfi_bank_o)
  );

  assign dfi_cke_o     = out_ctl.cke;
  assign dfi_odt_o     = out_ctl.odt;
  assign dfi_reset_n_o = out_ctl.reset_n;
  assign dfi_cs_n_o    = out_ctl.cs_n;
  assign dfi_ras_n_o   = out_ctl.ras_n;
  assign dfi_cas_n_o   = out_ctl.cas_n;
  assign dfi_we_n_o    = out_ctl.we_n;

  a_r6_strobe_fires: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(fire && !ctrl[CTL_HWSEL] && cmd[CMD_CS]) |-> !dfi_cs_n_o);
  a_r8_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pulse && !ctrl[CTL_HWSEL]) |->
      (dfi_cs_n_o && dfi_ras_n_o && dfi_cas_n_o && dfi_we_n_o));
  a_r10_hw_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl[CTL_HWSEL] && $past(ctrl[CTL_HWSEL])) |-> !pulse);
endmodule

// File: tb/test_dfi_cmd_inject.sv
module test_dfi_cmd_inject;
  localparam int BASEW = 32'h9000 >> 2;

  logic        clk, rst_n;
  logic        cyc, stb, we;
  logic [29:0] adr;
  logic [31:0] wdat, rdat;
  logic        ack;
  logic        h_cke, h_odt, h_rst, h_cs, h_ras, h_cas, h_we;
  logic [15:0] h_addr, d_addr;
  logic [2:0]  h_bank, d_bank;
  logic        d_cke, d_odt, d_rst, d_cs, d_ras, d_cas, d_we;

  int tests = 0;
  int fails = 0;

  // snapshots: {cke,odt,reset_n,cs_n,ras_n,cas_n,we_n}
  logic [6:0]  pins_ack, pins_after;
  logic        ack_pre, ack_at, ack_post;
  logic [31:0] rd_at;
  logic [15:0] addr_ack;
  logic [2:0]  bank_ack;

  dfi_cmd_inject i_dfi_cmd_inject (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .hw_cke_i(h_cke), .hw_odt_i(h_odt), .hw_reset_n_i(h_rst),
    .hw_cs_n_i(h_cs), .hw_ras_n_i(h_ras), .hw_cas_n_i(h_cas), .hw_we_n_i(h_we),
    .hw_address_i(h_addr), .hw_bank_i(h_bank),
    .dfi_cke_o(d_cke), .dfi_odt_o(d_odt), .dfi_reset_n_o(d_rst),
    .dfi_cs_n_o(d_cs), .dfi_ras_n_o(d_ras), .dfi_cas_n_o(d_cas), .dfi_we_n_o(d_we),
    .dfi_address_o(d_addr), .dfi_bank_o(d_bank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] pins();
    return {d_cke, d_odt, d_rst, d_cs, d_ras, d_cas, d_we};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus access; samples ack and pins before, during and after acknowledge
  task automatic xfer(input logic [29:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    #1 ack_pre = ack;
    @(negedge clk);
    ack_at = ack; rd_at = rdat; pins_ack = pins();
    addr_ack = d_addr; bank_ack = d_bank;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    ack_post = ack; pins_after = pins();
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    xfer(30'(BASEW + (off >> 2)), 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] off);
    xfer(30'(BASEW + (off >> 2)), 1'b0, 32'h0);
  endtask

  // vector: {byte offset[7:0], write data[31:0], expected readback[31:0]}
  localparam logic [71:0] VEC [10] = '{
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {8'h0C, 32'h0000_0200, 32'h0000_0200},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0007},
    {8'h10, 32'h0000_0003, 32'h0000_0003},
    {8'h04, 32'h0000_00FF, 32'h0000_000F},
    {8'h04, 32'h0000_0003, 32'h0000_0003},
    {8'h08, 32'h0000_0001, 32'h0000_0000},
    {8'h00, 32'h0000_000E, 32'h0000_000E},
    {8'h00, 32'h0000_00F0, 32'h0000_0000},
    {8'h14, 32'h0000_0005, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0;
    h_cke = 1; h_odt = 1; h_rst = 1; h_cs = 0; h_ras = 1; h_cas = 0; h_we = 1;
    h_addr = 16'hA5C3; h_bank = 3'd5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 pins in reset", 32'(pins()), 32'b000_1111);
    check("R1 ack in reset", 32'(ack), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pins after reset", 32'(pins()), 32'b000_1111);
    rd(8'h00); check("R1 ctrl reset value", rd_at, 32'h0);
    rd(8'h0C); check("R1 addr reset value", rd_at, 32'h0);

    // R4/R2: table walk, write then read back
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64]);
      check($sformatf("R4 R2 readback vec %0d", i), rd_at, VEC[i][31:0]);
    end

    // R3: acknowledge timing
    wr(8'h00, 32'h0000_000E);
    check("R3 ack low at request", 32'(ack_pre), 32'd0);
    check("R3 ack one cycle later", 32'(ack_at), 32'd1);
    check("R3 ack single cycle", 32'(ack_post), 32'd0);

    // R5: control pins (ctrl 0x0E -> cke,odt,reset_n high)
    check("R5 ctrl 0x0E pins", 32'(pins_ack), 32'b111_1111);
    wr(8'h00, 32'h0000_000C);
    check("R5 ctrl 0x0C drops cke", 32'(pins_ack), 32'b011_1111);
    wr(8'h00, 32'h0000_000E);

    // R2: outside block is ignored
    xfer(30'h0, 1'b1, 32'h0000_0000);
    check("R2 foreign addr acked", 32'(ack_at), 32'd1);
    rd(8'h00); check("R2 foreign write ignored", rd_at, 32'h0000_000E);

    // R6 R7 R9: mode-register-set style command
    wr(8'h0C, 32'h0000_0200);
    wr(8'h10, 32'h0000_0002);
    wr(8'h04, 32'h0000_000F);
    check("R8 idle before strobe", 32'(pins_after[3:0]), 32'hF);
    wr(8'h08, 32'h0000_0001);
    check("R7 R6 0x0F all low on ack", 32'(pins_ack), 32'b111_0000);
    check("R6 R8 released next cycle", 32'(pins_after), 32'b111_1111);
    check("R9 address", 32'(addr_ack), 32'h200);
    check("R9 bank", 32'(bank_ack), 32'h2);

    // R7: WE|CS command
    wr(8'h0C, 32'h0000_0400);
    wr(8'h04, 32'h0000_0003);
    wr(8'h08, 32'h0000_0001);
    check("R7 0x03 cs_n we_n low", 32'(pins_ack[3:0]), 32'b0110);
    check("R9 address 0x400", 32'(addr_ack), 32'h400);

    // R6: strobe with bit0 clear issues nothing
    wr(8'h08, 32'h0000_0002);
    check("R6 no pulse for bit0=0", 32'(pins_ack[3:0]), 32'hF);

    // R10: hardware ownership
    wr(8'h04, 32'h0000_000F);
    wr(8'h00, 32'h0000_0001);
    check("R10 hw pins", 32'(pins_ack), 32'b111_0101);
    check("R10 hw address", 32'(addr_ack), 32'hA5C3);
    check("R10 hw bank", 32'(bank_ack), 32'd5);
    wr(8'h08, 32'h0000_0001);
    check("R10 strobe ignored ack", 32'(pins_ack), 32'b111_0101);
    check("R10 strobe ignored after", 32'(pins_after), 32'b111_0101);
    h_cs = 1; h_ras = 0; h_addr = 16'h1234;
    #1 check("R10 live follow", 32'({pins(), d_addr}), 32'({7'b111_1001, 16'h1234}));
    wr(8'h00, 32'h0000_000E);
    check("R10 no deferred cmd", 32'(pins_ack), 32'b111_1111);
    check("R10 no deferred cmd later", 32'(pins_after), 32'b111_1111);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 async reset pins", 32'(pins()), 32'b000_1111);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h04); check("R1 cmd cleared", rd_at, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule